// File: doc/BRIEF.md
# Static Branch Direction Guesser with Hint Override

This block sits in the fetch stage of a simple in-order five-stage pipeline and guesses the outcome of each decoded conditional branch without learning from history. It is given the branch's program counter, its computed target and a two-bit compile-time hint from the instruction word. From these it registers a taken / not-taken guess and the next fetch address. A branch that jumps backward, or to itself, is guessed taken and one that jumps forward is guessed not taken. A hint can force either guess.

When a branch resolves later in the pipeline, the resolve port returns the actual outcome, the target, the fall-through address and the same hint bits. The block works out the guess again from these values, so it stores no per-branch state. If the actual outcome differs from the guess, it raises a one-cycle flush that squashes the speculative fetch slot and drives the correct redirect address.

Two saturating counters track how many branches were resolved and how many were mispredicted.

Top module: `bdp_top`

## Requirements
- R1: With hint bit 1 clear (hint 00 or 01), a branch whose target is below its program counter (unsigned compare) is guessed taken, and the next fetch address is the target.
- R2: With hint bit 1 clear, a branch whose target is above its program counter is guessed not taken, and the next fetch address is the program counter plus 4.
- R3: With hint bit 1 clear, a branch whose target equals its program counter is guessed taken.
- R4: Hint 10 forces a not-taken guess and hint 11 forces a taken guess, whatever the branch direction.
- R5: A decoded instruction with the branch flag low gives pred_branch = 0 and pred_taken = 0, and the next fetch address is its program counter plus 4.
- R6: The prediction outputs are registered. They appear in the cycle after the decode inputs are sampled, and pred_valid follows dec_valid.
- R7: A resolve whose actual outcome differs from the recomputed guess raises flush for exactly the next cycle. The redirect address is the resolved target if the branch was actually taken, and the fall-through address otherwise.
- R8: A resolve whose actual outcome matches the guess leaves flush low.
- R9: A loop closed by an unhinted backward branch and run to completion causes exactly one misprediction, on its final, not-taken pass.
- R10: The branch counter adds one for each resolve, and the miss counter adds one for each mismatch. Both counters hold at all ones once they get there.
- R11: A synchronous active-high reset clears pred_valid, pred_branch, pred_taken, flush and both counters.
- R12: A prediction and a resolve in the same cycle are each handled in full, with neither one changing the other's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_is_branch | input | 1 | The decoded instruction is a conditional branch |
| dec_pc | input | ADDR_W | Program counter of the decoded instruction |
| dec_target | input | ADDR_W | Computed branch target |
| dec_hint | input | 2 | Compile-time hint: bit 1 enables override, bit 0 is the forced direction |
| pred_valid | output | 1 | The prediction outputs are valid |
| pred_branch | output | 1 | The prediction belongs to a branch |
| pred_taken | output | 1 | Guessed taken |
| pred_next_pc | output | ADDR_W | Next fetch address |
| res_valid | input | 1 | A branch is resolving |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_target | input | ADDR_W | Target of the resolving branch |
| res_fallthru | input | ADDR_W | Fall-through address (program counter plus 4) |
| res_hint | input | 2 | Hint bits of the resolving branch |
| flush | output | 1 | Squash the speculative slot |
| redirect_pc | output | ADDR_W | Corrected fetch address, meaningful while flush is high |
| branch_cnt | output | CNT_W | Saturating count of resolved branches |
| miss_cnt | output | CNT_W | Saturating count of mispredictions |

## Verification
A new guess and a resolve-driven flush can happen in the same cycle, because the decode and resolve ports are independent. The bench provokes this by presenting a forward unhinted branch at decode while a mispredicted backward branch resolves. In the next cycle it checks that the guess, the next fetch address, the flush, the redirect address and the counters each hold their own expected value. Counter saturation landing on a mismatching resolve is provoked on a narrow-counter instance and judged the same way.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned HINT_W = 2;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [HINT_W-1:0] {
    HINT_NONE_A = 2'b00,
    HINT_NONE_B = 2'b01,
    HINT_FORCE_NT = 2'b10,
    HINT_FORCE_T = 2'b11
  } hint_e;

  localparam int unsigned HINT_EN_BIT = 1;
  localparam int unsigned HINT_DIR_BIT = 0;
endpackage

// File: rtl/bdp_guess.sv
module bdp_guess
  import bdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [HINT_W-1:0] hint,
  output logic              taken
);
  logic backward;

  // a target at or below the branch counts as a loop-closing jump
  always_comb begin
    backward = (target <= pc);
    if (hint[HINT_EN_BIT]) taken = hint[HINT_DIR_BIT];
    else                   taken = backward;
  end
endmodule

// File: rtl/bdp_fetch.sv
module bdp_fetch
  import bdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic              dec_is_branch,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic [HINT_W-1:0] dec_hint,
  output logic              pred_valid,
  output logic              pred_branch,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic              guess;
  logic              take_now;
  logic [ADDR_W-1:0] next_now;

  bdp_guess #(.ADDR_W(ADDR_W)) u_guess (
    .pc(dec_pc), .target(dec_target), .hint(dec_hint), .taken(guess)
  );

  always_comb begin
    take_now = dec_is_branch & guess;
    next_now = take_now ? dec_target : dec_pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_branch  <= 1'b0;
      pred_taken   <= 1'b0;
      pred_next_pc <= '0;
    end else begin
      pred_valid <= dec_valid;
      if (dec_valid) begin
        pred_branch  <= dec_is_branch;
        pred_taken   <= take_now;
        pred_next_pc <= next_now;
      end else begin
        pred_branch <= 1'b0;
        pred_taken  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdp_resolve.sv
module bdp_resolve
  import bdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_fallthru,
  input  logic [HINT_W-1:0] res_hint,
  output logic              mismatch,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] branch_pc;
  logic              reguess;

  // recover the branch address from its fall-through so the guess can be rebuilt
  assign branch_pc = res_fallthru - STEP;

  bdp_guess #(.ADDR_W(ADDR_W)) u_reguess (
    .pc(branch_pc), .target(res_target), .hint(res_hint), .taken(reguess)
  );

  assign mismatch = res_valid & (res_taken != reguess);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush       <= 1'b0;
      redirect_pc <= '0;
    end else begin
      flush <= mismatch;
      if (mismatch) redirect_pc <= res_taken ? res_target : res_fallthru;
    end
  end
endmodule

// File: rtl/bdp_sat_cnt.sv
module bdp_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                        value <= '0;
    else if (inc && value != TOP)   value <= value + W'(1);
  end
endmodule

// File: rtl/bdp_top.sv
module bdp_top
  import bdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic              dec_is_branch,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic [1:0]        dec_hint,
  output logic              pred_valid,
  output logic              pred_branch,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_fallthru,
  input  logic [1:0]        res_hint,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [CNT_W-1:0]  branch_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);
  localparam int unsigned N_CNT = 2;

  logic                 mismatch;
  logic [N_CNT-1:0]     cnt_inc;
  logic [CNT_W-1:0]     cnt_val [N_CNT];

  bdp_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .dec_pc(dec_pc), .dec_target(dec_target), .dec_hint(dec_hint),
    .pred_valid(pred_valid), .pred_branch(pred_branch),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc)
  );

  bdp_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_taken(res_taken),
    .res_target(res_target), .res_fallthru(res_fallthru), .res_hint(res_hint),
    .mismatch(mismatch), .flush(flush), .redirect_pc(redirect_pc)
  );

  assign cnt_inc = {mismatch, res_valid};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    bdp_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[g]), .value(cnt_val[g])
    );
  end

  assign branch_cnt = cnt_val[0];
  assign miss_cnt   = cnt_val[1];
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_valid,
  input logic              dec_is_branch,
  input logic [ADDR_W-1:0] dec_pc,
  input logic [1:0]        dec_hint,
  input logic              pred_valid,
  input logic              pred_branch,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              res_valid,
  input logic              flush,
  input logic [CNT_W-1:0]  branch_cnt,
  input logic [CNT_W-1:0]  miss_cnt
);
  // R7: a flush always follows a resolve
  assert_flush_cause_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(res_valid));

  // R2 / R5: a not-taken guess fetches the next sequential word
  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> pred_next_pc == $past(dec_pc) + ADDR_W'(4));

  // R4: hint 11 forces taken
  assert_force_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_is_branch && dec_hint == 2'b11) |=> pred_taken);

  // R4: hint 10 forces not taken
  assert_force_not_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_is_branch && dec_hint == 2'b10) |=> !pred_taken);

  // R5: a non-branch never shows a taken guess
  assert_nonbranch_R5: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_branch) |-> !pred_taken);

  // R6: pred_valid tracks dec_valid one cycle later
  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> pred_valid);

  // R10: the miss counter moves only together with a flush
  assert_miss_with_flush_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(miss_cnt) |-> flush);

  // R10: misses never exceed resolved branches
  assert_miss_bound_R10: assert property (@(posedge clk) disable iff (rst)
    miss_cnt <= branch_cnt);
endmodule

bind bdp_top bdp_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
  .dec_pc(dec_pc), .dec_hint(dec_hint),
  .pred_valid(pred_valid), .pred_branch(pred_branch),
  .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
  .res_valid(res_valid), .flush(flush),
  .branch_cnt(branch_cnt), .miss_cnt(miss_cnt)
);

// File: tb/bdp_top_bench.sv
module bdp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SAT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          dec_valid = 0, dec_is_branch = 0;
  logic [AW-1:0] dec_pc = 0, dec_target = 0;
  logic [1:0]    dec_hint = 0;
  logic          pred_valid, pred_branch, pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          res_valid = 0, res_taken = 0;
  logic [AW-1:0] res_target = 0, res_fallthru = 0;
  logic [1:0]    res_hint = 0;
  logic          flush;
  logic [AW-1:0] redirect_pc;
  logic [31:0]   branch_cnt, miss_cnt;

  bdp_top #(.ADDR_W(AW), .CNT_W(32)) u_bdp_top (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .dec_pc(dec_pc), .dec_target(dec_target), .dec_hint(dec_hint),
    .pred_valid(pred_valid), .pred_branch(pred_branch),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_taken(res_taken),
    .res_target(res_target), .res_fallthru(res_fallthru), .res_hint(res_hint),
    .flush(flush), .redirect_pc(redirect_pc),
    .branch_cnt(branch_cnt), .miss_cnt(miss_cnt)
  );

  // narrow-counter instance for saturation
  logic             s_res_valid = 0, s_res_taken = 0;
  logic [AW-1:0]    s_res_target = 0, s_res_fallthru = 0;
  logic             s_pv, s_pb, s_pt, s_flush;
  logic [AW-1:0]    s_npc, s_redir;
  logic [SAT_W-1:0] s_bcnt, s_mcnt;

  bdp_top #(.ADDR_W(AW), .CNT_W(SAT_W)) u_bdp_top_sat (
    .clk(clk), .rst(rst),
    .dec_valid(1'b0), .dec_is_branch(1'b0),
    .dec_pc('0), .dec_target('0), .dec_hint(2'b00),
    .pred_valid(s_pv), .pred_branch(s_pb), .pred_taken(s_pt), .pred_next_pc(s_npc),
    .res_valid(s_res_valid), .res_taken(s_res_taken),
    .res_target(s_res_target), .res_fallthru(s_res_fallthru), .res_hint(2'b00),
    .flush(s_flush), .redirect_pc(s_redir),
    .branch_cnt(s_bcnt), .miss_cnt(s_mcnt)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change 1 time unit after an edge; results read 1 unit after the next edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    dec_valid = 0; dec_is_branch = 0; res_valid = 0; s_res_valid = 0;
  endtask

  task automatic decode(input logic br, input logic [AW-1:0] pc,
                        input logic [AW-1:0] tg, input logic [1:0] h);
    dec_valid = 1; dec_is_branch = br; dec_pc = pc; dec_target = tg; dec_hint = h;
  endtask

  task automatic resolve(input logic tk, input logic [AW-1:0] pc,
                         input logic [AW-1:0] tg, input logic [1:0] h);
    res_valid = 1; res_taken = tk; res_target = tg; res_fallthru = pc + 4; res_hint = h;
  endtask

  task automatic expect_pred(input string req, input logic tk, input logic [AW-1:0] npc);
    check(pred_valid === 1'b1, req, pred_valid, 1);
    check(pred_taken === tk, req, pred_taken, tk);
    check(pred_next_pc === npc, req, pred_next_pc, npc);
  endtask

  task automatic t_reset();
    check(pred_valid === 0 && pred_branch === 0 && pred_taken === 0, "R11 pred",
          {pred_valid, pred_branch, pred_taken}, 0);
    check(flush === 0, "R11 flush", flush, 0);
    check(branch_cnt === 0 && miss_cnt === 0, "R11 counters", {branch_cnt, miss_cnt}, 0);
  endtask

  task automatic t_direction();
    decode(1, 32'h0000_0200, 32'h0000_0100, 2'b00); step();
    expect_pred("R1 backward", 1, 32'h0000_0100);
    decode(1, 32'h8000_0000, 32'h7FFF_FFF0, 2'b01); step();
    expect_pred("R1 backward unsigned", 1, 32'h7FFF_FFF0);
    decode(1, 32'h0000_0100, 32'h0000_0180, 2'b00); step();
    expect_pred("R2 forward", 0, 32'h0000_0104);
    decode(1, 32'h7FFF_FFF0, 32'h8000_0000, 2'b01); step();
    expect_pred("R2 forward unsigned", 0, 32'h7FFF_FFF4);
    decode(1, 32'h0000_0440, 32'h0000_0440, 2'b00); step();
    expect_pred("R3 self", 1, 32'h0000_0440);
    idle(); step();
    check(pred_valid === 0, "R6 valid drops", pred_valid, 0);
  endtask

  task automatic t_hint();
    decode(1, 32'h0000_0200, 32'h0000_0100, 2'b10); step();
    expect_pred("R4 force not-taken backward", 0, 32'h0000_0204);
    decode(1, 32'h0000_0100, 32'h0000_0300, 2'b11); step();
    expect_pred("R4 force taken forward", 1, 32'h0000_0300);
    idle(); step();
  endtask

  task automatic t_nonbranch();
    decode(0, 32'h0000_0500, 32'h0000_0010, 2'b11); step();
    expect_pred("R5 non-branch", 0, 32'h0000_0504);
    check(pred_branch === 0, "R5 branch flag", pred_branch, 0);
    idle(); step();
  endtask

  task automatic t_resolve();
    logic [31:0] b0, m0;
    b0 = branch_cnt; m0 = miss_cnt;
    resolve(0, 32'h0000_0100, 32'h0000_0180, 2'b00); step(); // forward, not taken: match
    check(flush === 0, "R8 match", flush, 0);
    resolve(1, 32'h0000_0100, 32'h0000_0180, 2'b00); step(); // forward taken: miss
    check(flush === 1, "R7 flush", flush, 1);
    check(redirect_pc === 32'h0000_0180, "R7 redirect taken", redirect_pc, 32'h180);
    resolve(0, 32'h0000_0100, 32'h0000_0180, 2'b11); step(); // hinted taken, not taken
    check(flush === 1, "R7 flush hinted", flush, 1);
    check(redirect_pc === 32'h0000_0104, "R7 redirect fallthru", redirect_pc, 32'h104);
    idle(); step();
    check(flush === 0, "R7 one cycle", flush, 0);
    check(branch_cnt === b0 + 3, "R10 branch count", branch_cnt, b0 + 3);
    check(miss_cnt === m0 + 2, "R10 miss count", miss_cnt, m0 + 2);
  endtask

  task automatic t_loop();
    logic [31:0] m0;
    int flushes;
    m0 = miss_cnt; flushes = 0;
    for (int it = 0; it < 6; it++) begin
      decode(1, 32'h0000_0a20, 32'h0000_0a00, 2'b00);
      resolve(it != 5, 32'h0000_0a20, 32'h0000_0a00, 2'b00);
      step();
      if (flush === 1) flushes++;
      check(pred_taken === 1, "R9 loop guess", pred_taken, 1);
    end
    idle(); step();
    check(flushes == 1, "R9 one miss per loop", flushes, 1);
    check(miss_cnt === m0 + 1, "R9 miss count", miss_cnt, m0 + 1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] b0, m0;
    b0 = branch_cnt; m0 = miss_cnt;
    decode(1, 32'h0000_0300, 32'h0000_0340, 2'b00);
    resolve(0, 32'h0000_0600, 32'h0000_0580, 2'b00);
    step();
    expect_pred("R12 prediction", 0, 32'h0000_0304);
    check(flush === 1, "R12 flush", flush, 1);
    check(redirect_pc === 32'h0000_0604, "R12 redirect", redirect_pc, 32'h604);
    check(branch_cnt === b0 + 1 && miss_cnt === m0 + 1, "R12 counters",
          {branch_cnt, miss_cnt}, {b0 + 1, m0 + 1});
    idle(); step();
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 20; k++) begin
      s_res_valid = 1; s_res_taken = 1;
      s_res_target = 32'h0000_0900; s_res_fallthru = 32'h0000_0804; // forward taken: miss
      step();
      check(s_flush === 1, "R10 flush at saturation", s_flush, 1);
    end
    idle(); step();
    check(s_bcnt === 4'hF, "R10 branch saturate", s_bcnt, 4'hF);
    check(s_mcnt === 4'hF, "R10 miss saturate", s_mcnt, 4'hF);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        step(); step();
        rst = 0;
        t_reset();
        t_direction();
        t_hint();
        t_nonbranch();
        t_resolve();
        t_loop();
        t_same_cycle();
        t_saturate();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule